// File: doc/BRIEF.md
# Delta-Phase Single-Tone Frequency Estimator

This block estimates the frequency of one tone from a stream of one-bit samples, as produced by a latched comparator used as a single-bit digitizer. Each accepted bit becomes +1 or −1. The stream is rotated by a complex sequence at a quarter of the sample rate, so the real input yields in-phase and quadrature parts directly. Each part passes through a short moving-sum low-pass filter. A small table-based arctangent turns each I/Q pair into an 8-bit phase. Successive phases are differenced modulo one turn and summed while a pulse gate is high.

When the gate falls, the block presents the summed phase steps and the number of steps. The consumer divides the sum by the count to get the mean step. The estimated frequency is Fs/4 + mean_step × Fs/256.

Samples enter on a valid/ready stream. `in_ready` is held high at all times, so the block never applies back-pressure. A sample is taken on every clock edge where `in_valid` is high. The gate is a sideband bit of that stream and is read only with an accepted sample. The result side has no ready signal. `out_valid` is a single-cycle pulse, and `out_sum` and `out_count` hold their values until the next pulse.

Top module: `dphase_freq_est`

## Requirements
- R1: An accepted bit of 1 maps to +1 and a bit of 0 maps to −1. The mapped value is multiplied by a rotation that starts at 1 after reset and advances only on accepted samples, through the sequence 1, −j, −1, +j.
- R2: I and Q are each the sum of the last 8 accepted rotated values. Taps not yet filled since reset count as zero.
- R3: The phase code uses 256 codes per turn. Code 0 lies along +I and code 64 along +Q. With ax=|I| and ay=|Q|: if ay ≤ ax the angle is a = T(floor(16·ay/ax)), otherwise a = 64 − T(floor(16·ax/ay)), where T(k) = round(atan(k/16)·128/π). The phase is a when I≥0 and Q≥0, 128−a when I<0 and Q≥0, 128+a when I<0 and Q<0, and (256−a) mod 256 when I≥0 and Q<0.
- R4: When I = Q = 0 the phase keeps its previous value. The phase is 0 after reset.
- R5: Each phase step is (phase − previous phase) mod 256, read as a signed 8-bit value in −128..127.
- R6: For each accepted sample with the gate high, the step is added to the sum and the count is incremented. The exception is the first gated sample after a gate-low sample or after reset, which adds nothing.
- R7: For the first accepted gate-low sample after a gated one, `out_valid` pulses for one cycle on the third rising edge counting the acceptance edge as the first. At that pulse `out_sum` and `out_count` carry the totals, and both internal totals restart from zero.
- R8: A stream whose gate stays low produces no `out_valid` pulse.
- R9: `in_ready` is always high. Cycles with `in_valid` low change nothing, so the same samples with idle cycles between them give the same result.
- R10: A tone at exactly Fs/4, with the filter already filled, gives a sum of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Always high; the block takes every sample |
| in_bit | input | 1 | One-bit sample |
| in_gate | input | 1 | Pulse gate, read together with the sample |
| out_valid | output | 1 | One-cycle result pulse |
| out_sum | output | ACC_W (24) | Signed sum of phase steps |
| out_count | output | CNT_W (16) | Number of summed steps |

## Verification
The bench drives tones above and below Fs/4 whose phase steps cross the ±128 boundary on every turn. A wrong wrap would flip the sign of many steps and upset the sum. A burst gated for one sample must report a count of 0. An off-by-one in skipping the first gated step would report 1 with a stray sum instead. An all-ones input drives I and Q to zero, and an arctangent that did not hold its phase would add jumps to a sum that should stay 0. Idle cycles inserted between samples would, if they advanced the rotation or the filter, change the result away from the gap-free reference.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
  localparam int PH_W = 8;
  localparam int QTR  = 64;

  // First-octant angle in phase codes: round(atan(k/16)*128/pi), k = 0..16
  function automatic logic [5:0] oct_angle(input logic [4:0] k);
    logic [5:0] r;
    case (k)
      5'd0:  r = 6'd0;
      5'd1:  r = 6'd3;
      5'd2:  r = 6'd5;
      5'd3:  r = 6'd8;
      5'd4:  r = 6'd10;
      5'd5:  r = 6'd12;
      5'd6:  r = 6'd15;
      5'd7:  r = 6'd17;
      5'd8:  r = 6'd19;
      5'd9:  r = 6'd21;
      5'd10: r = 6'd23;
      5'd11: r = 6'd25;
      5'd12: r = 6'd26;
      5'd13: r = 6'd28;
      5'd14: r = 6'd29;
      5'd15: r = 6'd31;
      default: r = 6'd32;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dpf_mix_fir.sv
module dpf_mix_fir #(
  parameter int TAPS  = 8,
  parameter int SUM_W = $clog2(TAPS) + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_bit,
  input  logic                    in_gate,
  output logic                    out_valid,
  output logic                    out_gate,
  output logic signed [SUM_W-1:0] out_i,
  output logic signed [SUM_W-1:0] out_q
);
  localparam int HALF = TAPS / 2;

  logic [1:0]        rot;
  logic signed [1:0] mix_i, mix_q;
  logic signed [1:0] tap_i [TAPS];
  logic signed [1:0] tap_q [TAPS];

  // rotation 1, -j, -1, +j applied to +/-1
  always_comb begin
    mix_i = 2'sb00;
    mix_q = 2'sb00;
    unique case (rot)
      2'd0: mix_i = in_bit ? 2'sb01 : 2'sb11;
      2'd1: mix_q = in_bit ? 2'sb11 : 2'sb01;
      2'd2: mix_i = in_bit ? 2'sb11 : 2'sb01;
      2'd3: mix_q = in_bit ? 2'sb01 : 2'sb11;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rot       <= 2'd0;
      out_valid <= 1'b0;
      out_gate  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        rot      <= rot + 2'd1;
        out_gate <= in_gate;
      end
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tap_i[t] <= 2'sb00;
        tap_q[t] <= 2'sb00;
      end else if (in_valid) begin
        if (t == 0) begin
          tap_i[t] <= mix_i;
          tap_q[t] <= mix_q;
        end else begin
          tap_i[t] <= tap_i[t-1];
          tap_q[t] <= tap_q[t-1];
        end
      end
    end
  end

  always_comb begin
    out_i = '0;
    out_q = '0;
    for (int t = 0; t < TAPS; t++) begin
      out_i = out_i + {{(SUM_W-2){tap_i[t][1]}}, tap_i[t]};
      out_q = out_q + {{(SUM_W-2){tap_q[t][1]}}, tap_q[t]};
    end
  end

  // only every other tap can be nonzero in each rail
  assert_sum_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_i <= SUM_W'(HALF)) && (out_i >= -SUM_W'(HALF)) &&
    (out_q <= SUM_W'(HALF)) && (out_q >= -SUM_W'(HALF)));
endmodule

// File: rtl/dpf_atan.sv
module dpf_atan #(
  parameter int SUM_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_gate,
  input  logic signed [SUM_W-1:0]   in_i,
  input  logic signed [SUM_W-1:0]   in_q,
  output logic                      out_valid,
  output logic                      out_gate,
  output logic [dpf_pkg::PH_W-1:0]  out_ph
);
  import dpf_pkg::*;

  logic [SUM_W-1:0]   ax, ay, num, den;
  logic [SUM_W+3:0]   scaled;
  logic [4:0]         k;
  logic               steep, zero;
  logic [5:0]         oct;
  logic [PH_W-1:0]    base, ph_next;

  always_comb begin
    ax     = in_i[SUM_W-1] ? SUM_W'(-in_i) : SUM_W'(in_i);
    ay     = in_q[SUM_W-1] ? SUM_W'(-in_q) : SUM_W'(in_q);
    steep  = ay > ax;
    num    = steep ? ax : ay;
    den    = steep ? ay : ax;
    zero   = (ax == '0) && (ay == '0);
    scaled = {num, 4'b0000};
    k      = (den == '0) ? 5'd0 : 5'(scaled / {4'b0000, den});
    oct    = oct_angle(k);
    base   = steep ? (PH_W'(QTR) - {2'b00, oct}) : {2'b00, oct};
    case ({in_i[SUM_W-1], in_q[SUM_W-1]})
      2'b00:   ph_next = base;
      2'b10:   ph_next = PH_W'(128) - base;
      2'b11:   ph_next = PH_W'(128) + base;
      default: ph_next = PH_W'(0) - base;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_gate  <= 1'b0;
      out_ph    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_gate <= in_gate;
        if (!zero) out_ph <= ph_next;
      end
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_i == '0 && in_q == '0) |=> $stable(out_ph));

  assert_axis_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_q == '0 && in_i > 0) |=> (out_ph == '0));
endmodule

// File: rtl/dpf_accum.sv
module dpf_accum #(
  parameter int ACC_W = 24,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_gate,
  input  logic [dpf_pkg::PH_W-1:0]  in_ph,
  output logic                      out_valid,
  output logic signed [ACC_W-1:0]   out_sum,
  output logic [CNT_W-1:0]          out_count
);
  import dpf_pkg::*;

  logic [PH_W-1:0]         last_ph;
  logic                    last_g;
  logic signed [PH_W-1:0]  step;
  logic signed [ACC_W-1:0] acc;
  logic [CNT_W-1:0]        cnt;

  assign step = in_ph - last_ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_ph   <= '0;
      last_g    <= 1'b0;
      acc       <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_count <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        last_ph <= in_ph;
        last_g  <= in_gate;
        if (in_gate) begin
          if (last_g) begin
            acc <= acc + {{(ACC_W-PH_W){step[PH_W-1]}}, step};
            cnt <= cnt + 1'b1;
          end
        end else if (last_g) begin
          out_valid <= 1'b1;
          out_sum   <= acc;
          out_count <= cnt;
          acc       <= '0;
          cnt       <= '0;
        end
      end
    end
  end

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_clear_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (acc == '0 && cnt == '0));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == '0));
endmodule

// File: rtl/dphase_freq_est.sv
module dphase_freq_est #(
  parameter int TAPS  = 8,
  parameter int ACC_W = 24,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_bit,
  input  logic                    in_gate,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_sum,
  output logic [CNT_W-1:0]        out_count
);
  import dpf_pkg::*;

  localparam int SUM_W = $clog2(TAPS) + 2;

  logic                    v1, g1, v2, g2;
  logic signed [SUM_W-1:0] s_i, s_q;
  logic [PH_W-1:0]         ph;

  assign in_ready = 1'b1;

  dpf_mix_fir #(.TAPS(TAPS), .SUM_W(SUM_W)) u_mix (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid && in_ready),
    .in_bit(in_bit), .in_gate(in_gate),
    .out_valid(v1), .out_gate(g1), .out_i(s_i), .out_q(s_q));

  dpf_atan #(.SUM_W(SUM_W)) u_atan (
    .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_gate(g1),
    .in_i(s_i), .in_q(s_q),
    .out_valid(v2), .out_gate(g2), .out_ph(ph));

  dpf_accum #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_gate(g2), .in_ph(ph),
    .out_valid(out_valid), .out_sum(out_sum), .out_count(out_count));
endmodule

// File: tb/sim_dphase_freq_est.sv
`timescale 1ns/1ps
module sim_dphase_freq_est;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_bit = 1'b0, in_gate = 1'b0;
  logic in_ready, out_valid;
  logic signed [23:0] out_sum;
  logic [15:0] out_count;

  always #10 clk = ~clk;

  dphase_freq_est u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_gate(in_gate), .out_valid(out_valid),
    .out_sum(out_sum), .out_count(out_count));

  // vector table: tone offset in codes/sample, gated length, expected count
  localparam int NV = 6;
  localparam int VEC_D[NV]   = '{0, 12, -12, 40, -55, 90};
  localparam int VEC_L[NV]   = '{20, 33, 16, 40, 25, 18};
  localparam int VEC_CNT[NV] = '{19, 32, 15, 39, 24, 17};

  int n_chk = 0, n_bad = 0, cyc = 0, ndone = 0;
  bit pend = 0;
  longint exp_s, last_sum;
  int exp_c, exp_cyc, last_cnt;

  int m_i[8], m_q[8];
  int m_rot = 0, m_ph = 0, m_lph = 0, m_cnt = 0;
  bit m_lg = 0;
  longint m_acc = 0;

  task automatic chk(bit ok, string tag, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int tbl(int k);
    return $rtoi($floor($atan(k / 16.0) * 128.0 / 3.14159265358979 + 0.5));
  endfunction

  task automatic model_step(bit b, bit g);
    int s, mi, mq, si, sq, ax, ay, a, st;
    s = b ? 1 : -1; mi = 0; mq = 0;
    case (m_rot)
      0: mi = s;
      1: mq = -s;
      2: mi = -s;
      default: mq = s;
    endcase
    m_rot = (m_rot + 1) % 4;
    for (int t = 7; t > 0; t--) begin m_i[t] = m_i[t-1]; m_q[t] = m_q[t-1]; end
    m_i[0] = mi; m_q[0] = mq;
    si = 0; sq = 0;
    for (int t = 0; t < 8; t++) begin si += m_i[t]; sq += m_q[t]; end
    if (si != 0 || sq != 0) begin
      ax = si < 0 ? -si : si; ay = sq < 0 ? -sq : sq;
      if (ay <= ax) a = tbl((ay * 16) / ax); else a = 64 - tbl((ax * 16) / ay);
      if (si >= 0 && sq >= 0) m_ph = a;
      else if (si < 0 && sq >= 0) m_ph = 128 - a;
      else if (si < 0) m_ph = 128 + a;
      else m_ph = (256 - a) % 256;
    end
    st = (((m_ph - m_lph) % 256) + 256) % 256;
    if (st >= 128) st -= 256;
    if (g) begin
      if (m_lg) begin m_acc += st; m_cnt++; end
    end else if (m_lg) begin
      pend = 1; exp_s = m_acc; exp_c = m_cnt; exp_cyc = cyc + 3;
      m_acc = 0; m_cnt = 0;
    end
    m_lph = m_ph; m_lg = g;
  endtask

  task automatic send(bit b, bit g);
    @(negedge clk);
    in_valid = 1'b1; in_bit = b; in_gate = g;
    model_step(b, g);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_bit = ~in_bit; in_gate = ~in_gate;
    end
  endtask

  task automatic burst(int d, int len, bit gaps);
    real f;
    int n;
    f = 0.25 + d / 256.0;
    n = 0;
    for (int i = 0; i < 8 + len + 4; i++) begin
      send($cos(2.0 * 3.14159265358979 * f * n + 0.3) >= 0.0, (i >= 8) && (i < 8 + len));
      n++;
      if (gaps && (i % 3 == 0)) idle(1 + i % 2);
    end
    idle(6);
  endtask

  always @(posedge clk) begin
    #2;
    cyc++;
    if (rst_n && out_valid) begin
      if (!pend) chk(1'b0, "R8 unexpected done", 1, 0);
      else begin
        chk(cyc == exp_cyc, "R7 done latency", cyc, exp_cyc);
        chk(out_count == 16'(exp_c), "R6 step count", out_count, exp_c);
        chk(out_sum == 24'(exp_s), "R1/R2/R3/R5 step sum", out_sum, exp_s);
        last_sum = out_sum; last_cnt = out_count;
        pend = 0; ndone++;
      end
    end else if (pend && cyc >= exp_cyc) begin
      chk(1'b0, "R7 done missing", 0, 1);
      pend = 0;
    end
  end

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int nd0;
    for (int t = 0; t < 8; t++) begin m_i[t] = 0; m_q[t] = 0; end
    idle(4);
    chk(out_valid == 1'b0, "R7 reset out_valid", out_valid, 0);
    chk(out_sum == 0, "R7 reset out_sum", out_sum, 0);
    chk(out_count == 0, "R7 reset out_count", out_count, 0);
    chk(in_ready == 1'b1, "R9 in_ready high", in_ready, 1);
    @(negedge clk); rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      nd0 = ndone;
      burst(VEC_D[v], VEC_L[v], 1'b0);
      chk(ndone == nd0 + 1, "R7 one done per burst", ndone - nd0, 1);
      chk(last_cnt == VEC_CNT[v], "R6 table count", last_cnt, VEC_CNT[v]);
      if (VEC_D[v] == 0) chk(last_sum == 0, "R10 quarter-rate sum", last_sum, 0);
    end

    // R8: gate held low
    nd0 = ndone;
    for (int i = 0; i < 30; i++) send(i[1], 1'b0);
    idle(6);
    chk(ndone == nd0, "R8 no done with gate low", ndone - nd0, 0);

    // R6: single gated sample
    send(1'b1, 1'b0); send(1'b0, 1'b1); send(1'b1, 1'b0);
    idle(6);
    chk(last_cnt == 0, "R6 single sample count", last_cnt, 0);
    chk(last_sum == 0, "R6 single sample sum", last_sum, 0);

    // R9: idle gaps inside the stream
    nd0 = ndone;
    burst(12, 33, 1'b1);
    chk(ndone == nd0 + 1, "R9 gapped burst done", ndone - nd0, 1);
    chk(last_cnt == 32, "R9 gapped burst count", last_cnt, 32);

    // R4: constant input gives I=Q=0, phase held
    for (int i = 0; i < 8; i++) send(1'b1, 1'b0);
    for (int i = 0; i < 20; i++) send(1'b1, 1'b1);
    send(1'b1, 1'b0);
    idle(6);
    chk(last_sum == 0, "R4 held phase sum", last_sum, 0);
    chk(last_cnt == 19, "R4 held phase count", last_cnt, 19);

    chk(pend == 1'b0, "R7 no outstanding result", pend, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule